// File: doc/BRIEF.md
# Glitchless Configuration Clock Generator

This block produces the configuration clock that a device drives onto its board-level clock pin while it is the master of a configuration chain. It divides a fast free-running oscillator down to a slow default rate, and keeps that rate until a rate code arrives from the configuration stream. Once a code arrives, the generator moves to the matching rate at a point where neither the high nor the low level of the output is cut short.

The output runs from the moment master operation is enabled. When the external completion signal goes high, the generator produces a fixed, parameterised number of further rising edges. It then parks the clock low. When the block is not the master, the clock is held low and the drive enable is off, so the pin can float or be driven by others. The completion signal and the rate-load strobe are assumed to be synchronous to the oscillator.

Top module: `cfgclk_gen`

## Requirements
- R1: While `master_en_i` is low, both `cfg_clk_o` and `cfg_clk_oe_o` are low. A rate load in this state produces no toggling.
- R2: The half-period of the output, in oscillator cycles, is `SLOW_HALF >> code` with a floor of 1. With the default `SLOW_HALF` = 8 this gives codes 0/1/2/3 → 8/4/2/1. Without any load the ratio of code `DEF_CODE` = 1 (half-period 4) is used, which is 2.5 MHz from a 20 MHz oscillator.
- R3: The first edge that samples `master_en_i` high raises `cfg_clk_oe_o`. The output then holds a full low phase of one half-period and rises on oscillator edge H+1, where H is the active half-period.
- R4: A code loaded with `freq_load_i` while the clock runs takes effect at the next high-to-low transition of the output. The high phase in progress completes at the old width, and the following low phase uses the new width.
- R5: Across a rate change, every completed high or low pulse lasts exactly the old or the new half-period. No runt pulse occurs.
- R6: A code loaded while master operation is off is the one used once master operation starts.
- R7: After `done_i` is sampled high, the output produces exactly `TAIL_CYCLES` further rising edges. Any rising edge on that same sampling edge is not counted. The output then stays low while `cfg_clk_oe_o` stays high. `TAIL_CYCLES` must lie in 100..500.
- R8: Once stopped, the output stays low regardless of `done_i` or further rate loads, until `master_en_i` drops.
- R9: Dropping `master_en_i` forces both outputs low on the next oscillator edge, even in the middle of a high phase.
- R10: `rst_ni` asserted low clears both outputs at once and restores the default ratio. Its release is synchronised to the oscillator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast internal oscillator |
| rst_ni | input | 1 | Asynchronous active-low reset |
| master_en_i | input | 1 | High when the device is configuration master |
| freq_code_i | input | CODE_W | Rate code from the configuration stream |
| freq_load_i | input | 1 | One-cycle strobe that loads `freq_code_i` |
| done_i | input | 1 | External configuration-complete level |
| cfg_clk_o | output | 1 | Configuration clock |
| cfg_clk_oe_o | output | 1 | Drive enable for the configuration clock pin |

## Verification
The bench measures every high and low pulse width across a sequence of rate changes: fast to slow, slow to fast, and back to the default. A divider that swapped ratios mid-phase would show a pulse matching neither the old nor the new width. One that swapped at the rising transition would leave a high phase at the new width.

It counts the rising edges after the completion signal. An off-by-one tail counter, or one that counts the edge coinciding with the completion sample, would report 99 or 101 edges. A stop taken on a rising transition would leave the pin parked high.

It also covers the start latency, loads made while idle, enable removal in the middle of a high phase, and an asynchronous reset during running. Each of these would show a late first edge, a stale ratio, or a clock stuck high.

// File: rtl/cfgclk_pkg.sv
package cfgclk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_TAIL = 2'd2,
    ST_STOP = 2'd3
  } cfgclk_state_e;

  // Half-period in oscillator cycles for a rate code: slowest >> code, floor 1.
  function automatic int unsigned cfgclk_half(input int unsigned slowest,
                                              input int unsigned code);
    int unsigned h;
    h = slowest >> code;
    return (h == 0) ? 1 : h;
  endfunction

endpackage

// File: rtl/cfgclk_rst_sync.sv
module cfgclk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/cfgclk_divider.sv
module cfgclk_divider
  import cfgclk_pkg::*;
#(
  parameter int SLOW_HALF = 8,
  parameter int CODE_W    = 2,
  parameter int DEF_CODE  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              load_i,
  output logic              clk_o,
  output logic              rise_o,
  output logic              fall_o
);

  localparam int CNT_W = $clog2(SLOW_HALF + 1);
  localparam int LEN_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] DEF_HALF = CNT_W'(cfgclk_half(SLOW_HALF, DEF_CODE));

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] half_q, half_d;
  logic [CNT_W-1:0] pend_q, pend_d;
  logic             pvld_q, pvld_d;
  logic             lvl_q, lvl_d;
  logic             tick;
  logic             swap_ok;

  assign tick    = run_i && (cnt_q == half_q - CNT_W'(1));
  assign swap_ok = !run_i || (tick && lvl_q);

  always_comb begin
    cnt_d  = cnt_q;
    lvl_d  = lvl_q;
    half_d = half_q;
    pend_d = pend_q;
    pvld_d = pvld_q;
    if (!run_i) begin
      cnt_d = '0;
      lvl_d = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      lvl_d = !lvl_q;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
    if (pvld_q && swap_ok) begin
      half_d = pend_q;
      pvld_d = 1'b0;
    end
    if (load_i) begin
      pend_d = CNT_W'(cfgclk_half(SLOW_HALF, int'(code_i)));
      pvld_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lvl_q  <= 1'b0;
      half_q <= DEF_HALF;
      pend_q <= DEF_HALF;
      pvld_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      lvl_q  <= lvl_d;
      half_q <= half_d;
      pend_q <= pend_d;
      pvld_q <= pvld_d;
    end
  end

  assign clk_o  = lvl_q;
  assign rise_o = tick && !lvl_q;
  assign fall_o = tick && lvl_q;

  // Length of the current output level, used only by the checks below.
  logic [LEN_W-1:0] len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             len_q <= '0;
    else if (lvl_d != lvl_q) len_q <= '0;
    else if (!(&len_q))      len_q <= len_q + LEN_W'(1);
  end

  // R5
  high_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && fall_o) |-> (len_q + LEN_W'(1) == {1'b0, half_q}));

  // R4
  swap_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(half_q) |-> !lvl_q);

endmodule

// File: rtl/cfgclk_seq.sv
module cfgclk_seq
  import cfgclk_pkg::*;
#(
  parameter int TAIL_CYCLES = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic master_en_i,
  input  logic done_i,
  input  logic rise_i,
  input  logic fall_i,
  output logic run_o,
  output logic oe_o
);

  localparam int TW = $clog2(TAIL_CYCLES + 1);
  localparam logic [TW-1:0] TAIL_LAST = TW'(TAIL_CYCLES);

  cfgclk_state_e    state_q, state_d;
  logic [TW-1:0]    tail_q, tail_d;

  always_comb begin
    state_d = state_q;
    if (!master_en_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: state_d = ST_RUN;
        ST_RUN:  if (done_i) state_d = ST_TAIL;
        ST_TAIL: if (fall_i && tail_q == TAIL_LAST) state_d = ST_STOP;
        default: state_d = ST_STOP;
      endcase
    end
  end

  always_comb begin
    tail_d = tail_q;
    if (state_q != ST_TAIL) tail_d = '0;
    else if (rise_i)        tail_d = tail_q + TW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tail_q  <= '0;
    end else begin
      state_q <= state_d;
      tail_q  <= tail_d;
    end
  end

  assign run_o = master_en_i && ((state_q == ST_RUN) || (state_q == ST_TAIL));
  assign oe_o  = (state_q != ST_IDLE);

  // R7
  initial begin
    tail_range_chk: assert (TAIL_CYCLES >= 100 && TAIL_CYCLES <= 500)
      else $error("TAIL_CYCLES out of range");
  end

  // R7
  tail_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tail_q <= TAIL_LAST);

endmodule

// File: rtl/cfgclk_gen.sv
module cfgclk_gen #(
  parameter int SLOW_HALF   = 8,
  parameter int CODE_W      = 2,
  parameter int DEF_CODE    = 1,
  parameter int TAIL_CYCLES = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_en_i,
  input  logic [CODE_W-1:0] freq_code_i,
  input  logic              freq_load_i,
  input  logic              done_i,
  output logic              cfg_clk_o,
  output logic              cfg_clk_oe_o
);

  logic rst_n;
  logic run;
  logic rise;
  logic fall;

  cfgclk_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  cfgclk_seq #(.TAIL_CYCLES(TAIL_CYCLES)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .master_en_i (master_en_i),
    .done_i      (done_i),
    .rise_i      (rise),
    .fall_i      (fall),
    .run_o       (run),
    .oe_o        (cfg_clk_oe_o)
  );

  cfgclk_divider #(
    .SLOW_HALF (SLOW_HALF),
    .CODE_W    (CODE_W),
    .DEF_CODE  (DEF_CODE)
  ) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .run_i  (run),
    .code_i (freq_code_i),
    .load_i (freq_load_i),
    .clk_o  (cfg_clk_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  // R1
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !cfg_clk_oe_o |-> !cfg_clk_o);

  // R9
  drop_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !master_en_i |=> (!cfg_clk_oe_o && !cfg_clk_o));

endmodule

// File: tb/tb_cfgclk_gen.sv
`timescale 1ns/1ps
module tb_cfgclk_gen;

  localparam int TAIL = 100;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       men;
  logic [1:0] code;
  logic       load;
  logic       done;
  logic       cclk;
  logic       oe;

  always #2.5 clk = ~clk;

  cfgclk_gen #(.TAIL_CYCLES(TAIL)) dut (
    .clk_i(clk), .rst_ni(rst_n), .master_en_i(men), .freq_code_i(code),
    .freq_load_i(load), .done_i(done), .cfg_clk_o(cclk), .cfg_clk_oe_o(oe)
  );

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  // Pulse-width monitor
  logic prev_lvl = 1'b0;
  int   run_len = 0;
  int   last_hi = 0;
  int   last_lo = 0;
  bit   watch = 0;
  int   w_old = 0;
  int   w_new = 0;
  int   bad   = 0;
  int   bad_w = 0;

  always @(negedge clk) begin
    if (cclk === prev_lvl) run_len++;
    else begin
      if (prev_lvl) last_hi = run_len; else last_lo = run_len;
      if (watch && run_len != w_old && run_len != w_new) begin
        bad++; bad_w = run_len;
      end
      run_len = 1;
    end
    prev_lvl = cclk;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic do_load(input logic [1:0] c);
    code = c; load = 1'b1;
    step(1);
    load = 1'b0;
  endtask

  localparam int NV = 6;
  localparam logic [1:0] VEC_CODE [NV] = '{2'd0, 2'd2, 2'd3, 2'd1, 2'd2, 2'd0};
  localparam int         VEC_HALF [NV] = '{8, 2, 1, 4, 2, 8};

  initial begin
    #400000;
    if (!ended) begin
      fails++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int first;
    int cur_half;
    int rises;
    int lowrun;
    logic pv;
    bit low_ok;
    rst_n = 1'b0; men = 1'b0; code = 2'd0; load = 1'b0; done = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(20);
    // R1 R10: reset and idle state
    check(cclk == 1'b0, "R1 clk idle", cclk, 0);
    check(oe == 1'b0, "R1 oe idle", oe, 0);

    // R3 R2: start latency and default rate
    men = 1'b1;
    first = 0;
    for (int n = 1; n <= 20; n++) begin
      step(1);
      if (n == 1) check(oe == 1'b1, "R3 oe on first edge", oe, 1);
      if (cclk && first == 0) first = n;
    end
    check(first == 5, "R3 first rise edge", first, 5);
    step(40);
    check(last_hi == 4, "R2 default high width", last_hi, 4);
    check(last_lo == 4, "R2 default low width", last_lo, 4);

    // R4 R5: table of rate changes
    cur_half = 4;
    for (int v = 0; v < NV; v++) begin
      bad = 0; w_old = cur_half; w_new = VEC_HALF[v]; watch = 1;
      do_load(VEC_CODE[v]);
      step(80);
      watch = 0;
      check(bad == 0, "R5 no runt pulse", bad_w, VEC_HALF[v]);
      check(last_hi == VEC_HALF[v], "R4 high width after load", last_hi, VEC_HALF[v]);
      check(last_lo == VEC_HALF[v], "R4 low width after load", last_lo, VEC_HALF[v]);
      cur_half = VEC_HALF[v];
    end

    // R4: the high phase in progress keeps the old width (half 8 -> 1)
    @(negedge clk); while (!cclk) @(negedge clk);
    #1;
    do_load(2'd3);
    while (cclk) begin
      @(negedge clk); #1;
    end
    check(last_hi == 8, "R4 old high kept", last_hi, 8);
    step(10);
    check(last_lo == 1, "R4 new low", last_lo, 1);
    do_load(2'd0);
    step(40);

    // R7: tail after done
    done = 1'b1;
    pv = cclk; rises = 0; lowrun = 0;
    for (int n = 1; n <= TAIL * 20 + 200 && lowrun < 40; n++) begin
      step(1);
      if (n > 1 && cclk && !pv) rises++;
      lowrun = cclk ? 0 : lowrun + 1;
      pv = cclk;
    end
    check(rises == TAIL, "R7 tail rising edges", rises, TAIL);
    check(cclk == 1'b0, "R7 parked low", cclk, 0);
    check(oe == 1'b1, "R7 oe kept", oe, 1);

    // R8: stays stopped despite loads and done dropping
    do_load(2'd3);
    done = 1'b0;
    low_ok = 1;
    for (int n = 0; n < 60; n++) begin
      step(1);
      if (cclk) low_ok = 0;
    end
    check(low_ok, "R8 stopped stays low", cclk, 0);

    // R9: enable removal
    men = 1'b0;
    step(1);
    check(oe == 1'b0, "R9 oe off", oe, 0);
    check(cclk == 1'b0, "R9 clk off", cclk, 0);

    // R6 R1: load while idle (code 2 -> half 2), no toggling
    do_load(2'd2);
    low_ok = 1;
    for (int n = 0; n < 10; n++) begin
      step(1);
      if (cclk) low_ok = 0;
    end
    check(low_ok, "R1 no toggle on idle load", cclk, 0);
    men = 1'b1;
    first = 0;
    for (int n = 1; n <= 20; n++) begin
      step(1);
      if (cclk && first == 0) first = n;
    end
    check(first == 3, "R6 idle-loaded rate start", first, 3);
    step(20);
    check(last_hi == 2, "R6 idle-loaded width", last_hi, 2);

    // R9: drop during a high phase
    @(negedge clk); while (!cclk) @(negedge clk);
    #1;
    men = 1'b0;
    step(1);
    check(cclk == 1'b0, "R9 mid-high drop", cclk, 0);
    men = 1'b1;
    step(30);

    // R10: asynchronous reset while running
    @(negedge clk); while (!cclk) @(negedge clk);
    #1;
    rst_n = 1'b0;
    #1;
    check(cclk == 1'b0, "R10 async clear clk", cclk, 0);
    check(oe == 1'b0, "R10 async clear oe", oe, 0);
    step(3);
    rst_n = 1'b1;
    step(60);
    check(last_hi == 4, "R10 default restored high", last_hi, 4);
    check(last_lo == 4, "R10 default restored low", last_lo, 4);

    ended = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule